// File: doc/BRIEF.md
# SPI Command Frame Generator

This block sits on the host side of a register-and-DMA SPI link and turns one command request into the byte sequence that opens a transaction. A request carries an opcode, a 24-bit address, a 32-bit argument, a clockless flag and a CRC7 enable. The argument is a transfer size for DMA commands and a data word for write commands. The generator picks the frame layout from the opcode and then hands the bytes out one at a time over a valid/ready pair. When checking is enabled, it closes the frame with a CRC7 byte. It does not drive the serial bit shifter, read responses or move payload data.

A request is taken only in state IDLE, when `start_i` is high. A supported opcode moves the FSM from IDLE to BODY, and the frame fields are captured at that edge. In BODY the FSM stays while body bytes are handed off. After the last body byte it goes from BODY to CRC when the CRC was enabled at capture, and from BODY to IDLE otherwise. CRC returns to IDLE once the check byte is accepted. An unsupported opcode leaves the FSM in IDLE and raises a one-cycle error pulse.

Top module: `cmdfrm_gen`

## Requirements
- R1: During and after reset, `busy_o`, `out_valid_o` and `err_o` are low and `len_o` is 0.
- R2: `start_i` with a supported opcode, sampled in IDLE, makes the opcode the first byte on the next cycle. From that cycle until the next capture, `len_o` holds the total byte count of the frame, including any check byte.
- R3: Single read (0xCA) sends the opcode, then address bits 23:16, 15:8 and 7:0. The body length is 4.
- R4: Internal read (0xC4) sends the opcode, then address bits 15:8 with bit 7 forced to 1 when `clockless_i` is high, then address bits 7:0, then 0x00. The body length is 4.
- R5: Internal write (0xC3) sends the opcode, then the two address bytes under the same clockless rule as R4, then `arg_i` as four bytes with the most significant byte first. The body length is 7.
- R6: Single write (0xC9) sends the opcode, then three address bytes with the most significant first, then four data bytes with the most significant first. The body length is 8.
- R7: Plain DMA (0xC1 write, 0xC2 read) sends the opcode, three address bytes, then `arg_i[15:0]` as two bytes, for a body of 6. Extended DMA (0xC7 write, 0xC8 read) sends the opcode, three address bytes, then `arg_i[23:0]` as three bytes, for a body of 7. All fields go most significant byte first.
- R8: When `crc_en_i` is high at capture, one extra byte follows the body. Its bits 7:1 hold a CRC7 over all body bytes, computed MSB first with polynomial x^7+x^3+1 (0x09) and seed 0x7F. Its bit 0 is 1. `len_o` is the body length plus 1.
- R9: While `out_valid_o` is high and `out_ready_i` is low, the same byte stays on `out_byte_o` and `out_valid_o` stays high.
- R10: An opcode outside the supported set, sampled with `start_i` in IDLE, gives `err_o` high for exactly the next cycle. It sets `len_o` to 0 and produces no byte.
- R11: `start_i` while `busy_o` is high is ignored. This includes the cycle of the final handoff: the running frame is unchanged, and no new frame follows.
- R12: `clockless_i` has no effect on any opcode other than internal read and internal write.
- R13: Reset command (0xCF) sends the opcode followed by three 0x00 bytes. The body length is 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, taken in IDLE |
| op_i | input | 8 | Command opcode |
| addr_i | input | 24 | Target address |
| arg_i | input | 32 | Size (DMA) or data word (writes) |
| clockless_i | input | 1 | Sets address bit 7 marker for internal commands |
| crc_en_i | input | 1 | Append CRC7 check byte |
| busy_o | output | 1 | Frame in progress (BODY or CRC) |
| len_o | output | 4 | Total bytes of the last captured frame, 0 after a rejected opcode |
| err_o | output | 1 | One-cycle pulse for an unsupported opcode |
| out_byte_o | output | 8 | Current frame byte |
| out_valid_o | output | 1 | `out_byte_o` is valid |
| out_ready_i | input | 1 | Consumer takes the byte at this edge |

## Verification
The two events that can fall in the same cycle are the handoff of a frame's final byte and a fresh `start_i`. That is exactly the point where a careless FSM would either clip the running frame or launch a second one. The bench raises `start_i` with a different opcode in the same cycle it accepts the last byte, and in a separate run it does the same partway through the body. It then checks that every byte of the original frame arrived intact. It also checks that `busy_o` and `out_valid_o` are low in the following cycle. Back-pressure is applied in a repeating stall pattern so that held bytes and CRC accumulation are judged under uneven handoff timing.

// File: rtl/cmdfrm_pkg.sv
package cmdfrm_pkg;
    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 24;
    localparam int ARG_W    = 32;
    localparam int CRC_W    = 7;
    localparam int MAX_BODY = 8;
    localparam int LEN_W    = $clog2(MAX_BODY + 2);
    localparam int IDX_W    = $clog2(MAX_BODY);

    localparam logic [CRC_W-1:0] CRC_SEED = 7'h7F;
    localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;

    localparam logic [BYTE_W-1:0] OP_DMA_WR  = 8'hC1;
    localparam logic [BYTE_W-1:0] OP_DMA_RD  = 8'hC2;
    localparam logic [BYTE_W-1:0] OP_INT_WR  = 8'hC3;
    localparam logic [BYTE_W-1:0] OP_INT_RD  = 8'hC4;
    localparam logic [BYTE_W-1:0] OP_XDMA_WR = 8'hC7;
    localparam logic [BYTE_W-1:0] OP_XDMA_RD = 8'hC8;
    localparam logic [BYTE_W-1:0] OP_SGL_WR  = 8'hC9;
    localparam logic [BYTE_W-1:0] OP_SGL_RD  = 8'hCA;
    localparam logic [BYTE_W-1:0] OP_RESET   = 8'hCF;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BODY = 2'd1,
        ST_CRC  = 2'd2
    } fsm_t;
endpackage

// File: rtl/cmdfrm_layout.sv
module cmdfrm_layout
    import cmdfrm_pkg::*;
(
    input  logic [BYTE_W-1:0]          op,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [ARG_W-1:0]           arg,
    input  logic                       clockless,
    output logic                       legal,
    output logic [LEN_W-1:0]           body_len,
    output logic [MAX_BODY*BYTE_W-1:0] body
);
    logic [BYTE_W-1:0] a2, a1, a0, ia1;
    logic [BYTE_W-1:0] b [MAX_BODY];

    assign a2  = addr[23:16];
    assign a1  = addr[15:8];
    assign a0  = addr[7:0];
    assign ia1 = {a1[7] | clockless, a1[6:0]};

    always_comb begin
        legal    = 1'b1;
        body_len = '0;
        for (int i = 0; i < MAX_BODY; i++) b[i] = '0;
        b[0] = op;
        unique case (op)
            OP_SGL_RD: begin
                b[1] = a2; b[2] = a1; b[3] = a0;
                body_len = LEN_W'(4);
            end
            OP_INT_RD: begin
                b[1] = ia1; b[2] = a0; b[3] = '0;
                body_len = LEN_W'(4);
            end
            OP_RESET: begin
                body_len = LEN_W'(4);
            end
            OP_DMA_WR, OP_DMA_RD: begin
                b[1] = a2; b[2] = a1; b[3] = a0;
                b[4] = arg[15:8]; b[5] = arg[7:0];
                body_len = LEN_W'(6);
            end
            OP_XDMA_WR, OP_XDMA_RD: begin
                b[1] = a2; b[2] = a1; b[3] = a0;
                b[4] = arg[23:16]; b[5] = arg[15:8]; b[6] = arg[7:0];
                body_len = LEN_W'(7);
            end
            OP_INT_WR: begin
                b[1] = ia1; b[2] = a0;
                b[3] = arg[31:24]; b[4] = arg[23:16]; b[5] = arg[15:8]; b[6] = arg[7:0];
                body_len = LEN_W'(7);
            end
            OP_SGL_WR: begin
                b[1] = a2; b[2] = a1; b[3] = a0;
                b[4] = arg[31:24]; b[5] = arg[23:16]; b[6] = arg[15:8]; b[7] = arg[7:0];
                body_len = LEN_W'(8);
            end
            default: begin
                legal = 1'b0;
            end
        endcase
    end

    for (genvar g = 0; g < MAX_BODY; g++) begin : g_pack
        assign body[g*BYTE_W +: BYTE_W] = b[g];
    end
endmodule

// File: rtl/cmdfrm_crc7.sv
module cmdfrm_crc7
    import cmdfrm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seed_load,
    input  logic              shift_en,
    input  logic [BYTE_W-1:0] din,
    output logic [CRC_W-1:0]  crc
);
    logic [CRC_W-1:0] nxt;

    always_comb begin
        nxt = crc;
        for (int i = BYTE_W - 1; i >= 0; i--) begin
            if (nxt[CRC_W-1] ^ din[i])
                nxt = {nxt[CRC_W-2:0], 1'b0} ^ CRC_POLY;
            else
                nxt = {nxt[CRC_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         crc <= CRC_SEED;
        else if (seed_load) crc <= CRC_SEED;
        else if (shift_en)  crc <= nxt;
    end

    // R8
    excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seed_load |-> !shift_en);
endmodule

// File: rtl/cmdfrm_gen.sv
module cmdfrm_gen
    import cmdfrm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [7:0]        op_i,
    input  logic [23:0]       addr_i,
    input  logic [31:0]       arg_i,
    input  logic              clockless_i,
    input  logic              crc_en_i,
    output logic              busy_o,
    output logic [3:0]        len_o,
    output logic              err_o,
    output logic [7:0]        out_byte_o,
    output logic              out_valid_o,
    input  logic              out_ready_i
);
    fsm_t state_q, state_d;

    logic                       legal;
    logic [LEN_W-1:0]           body_len;
    logic [MAX_BODY*BYTE_W-1:0] body;
    logic [MAX_BODY*BYTE_W-1:0] frame_q;
    logic [LEN_W-1:0]           body_len_q;
    logic                       crc_en_q;
    logic [IDX_W-1:0]           idx_q;
    logic [CRC_W-1:0]           crc;
    logic                       take, accept, handoff, last_body;

    cmdfrm_layout u_layout (
        .op        (op_i),
        .addr      (addr_i),
        .arg       (arg_i),
        .clockless (clockless_i),
        .legal     (legal),
        .body_len  (body_len),
        .body      (body)
    );

    assign take      = start_i && (state_q == ST_IDLE);
    assign accept    = take && legal;
    assign handoff   = out_valid_o && out_ready_i;
    assign last_body = (idx_q == IDX_W'(body_len_q - LEN_W'(1)));

    cmdfrm_crc7 u_crc (
        .clk       (clk),
        .rst_n     (rst_n),
        .seed_load (accept),
        .shift_en  (handoff && (state_q == ST_BODY)),
        .din       (out_byte_o),
        .crc       (crc)
    );

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_BODY;
            ST_BODY: if (handoff && last_body) state_d = crc_en_q ? ST_CRC : ST_IDLE;
            ST_CRC:  if (handoff) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // captured frame, byte index, length and error pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_q    <= '0;
            body_len_q <= '0;
            crc_en_q   <= 1'b0;
            idx_q      <= '0;
            len_o      <= '0;
            err_o      <= 1'b0;
        end else begin
            err_o <= take && !legal;
            if (take) begin
                len_o <= legal ? body_len + LEN_W'(crc_en_i) : '0;
            end
            if (accept) begin
                frame_q    <= body;
                body_len_q <= body_len;
                crc_en_q   <= crc_en_i;
                idx_q      <= '0;
            end else if (handoff && (state_q == ST_BODY) && !last_body) begin
                idx_q <= idx_q + IDX_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        out_valid_o = 1'b0;
        busy_o      = 1'b0;
        out_byte_o  = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_BODY: begin
                out_valid_o = 1'b1;
                busy_o      = 1'b1;
                out_byte_o  = frame_q[int'(idx_q)*BYTE_W +: BYTE_W];
            end
            ST_CRC: begin
                out_valid_o = 1'b1;
                busy_o      = 1'b1;
                out_byte_o  = {crc, 1'b1};
            end
            default: ;
        endcase
    end

    // R2
    first_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && legal) |=> (out_valid_o && out_byte_o == $past(op_i)));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_byte_o)));

    // R10
    err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> ($past(start_i) && !$past(busy_o) && !out_valid_o));

    // R11
    end_only_on_handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(out_valid_o && out_ready_i));
endmodule

// File: tb/sim_cmdfrm_gen.sv
`timescale 1ns/1ps
module sim_cmdfrm_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  op_i = '0;
    logic [23:0] addr_i = '0;
    logic [31:0] arg_i = '0;
    logic        clockless_i = 1'b0;
    logic        crc_en_i = 1'b0;
    logic        busy_o;
    logic [3:0]  len_o;
    logic        err_o;
    logic [7:0]  out_byte_o;
    logic        out_valid_o;
    logic        out_ready_i = 1'b1;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    cmdfrm_gen u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .addr_i(addr_i), .arg_i(arg_i), .clockless_i(clockless_i),
        .crc_en_i(crc_en_i), .busy_o(busy_o), .len_o(len_o), .err_o(err_o),
        .out_byte_o(out_byte_o), .out_valid_o(out_valid_o), .out_ready_i(out_ready_i)
    );

    // {op, addr, arg, clockless, crc_en}
    localparam int NV = 16;
    localparam logic [65:0] VEC [NV] = '{
        {8'hCA, 24'h123456, 32'h0,        1'b0, 1'b0},
        {8'hCA, 24'h123456, 32'h0,        1'b0, 1'b1},
        {8'hC4, 24'h00ABCD, 32'h0,        1'b1, 1'b0},
        {8'hC4, 24'h002B10, 32'h0,        1'b0, 1'b1},
        {8'hC3, 24'h000012, 32'hDEADBEEF, 1'b1, 1'b1},
        {8'hC3, 24'h001234, 32'h89ABCDEF, 1'b0, 1'b0},
        {8'hC9, 24'h0A0B0C, 32'h01020304, 1'b0, 1'b0},
        {8'hC9, 24'hFEDCBA, 32'hCAFEF00D, 1'b0, 1'b1},
        {8'hC1, 24'h345678, 32'h00001234, 1'b0, 1'b0},
        {8'hC2, 24'h000100, 32'h0000FFFF, 1'b0, 1'b1},
        {8'hC7, 24'h0000F0, 32'h00ABCDEF, 1'b0, 1'b0},
        {8'hC8, 24'h7F7F7F, 32'h12345678, 1'b0, 1'b1},
        {8'hCF, 24'hFFFFFF, 32'hFFFFFFFF, 1'b0, 1'b1},
        {8'hCA, 24'h00FF00, 32'h0,        1'b1, 1'b0},
        {8'hC1, 24'h004000, 32'h00000102, 1'b1, 1'b1},
        {8'hC9, 24'h000000, 32'h00000000, 1'b0, 1'b1}
    };

    logic [7:0] exp_b [10];
    int         exp_n;

    task automatic chk(input bit ok, input string rq, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, expv);
        end
    endtask

    function automatic string req_of(input logic [7:0] op, input logic crc, input logic cl);
        if (crc) return "R8";
        if (cl && op != 8'hC4 && op != 8'hC3) return "R12";
        case (op)
            8'hCA: return "R3";
            8'hC4: return "R4";
            8'hC3: return "R5";
            8'hC9: return "R6";
            8'hCF: return "R13";
            default: return "R7";
        endcase
    endfunction

    function automatic logic [6:0] crc_model(input int n);
        logic [6:0] c = 7'h7F;
        for (int k = 0; k < n; k++) begin
            for (int j = 7; j >= 0; j--) begin
                logic fb;
                fb = c[6] ^ exp_b[k][j];
                c = {c[5:0], 1'b0};
                if (fb) c = c ^ 7'h09;
            end
        end
        return c;
    endfunction

    task automatic build_expect(input logic [65:0] v);
        logic [7:0]  op;
        logic [23:0] a;
        logic [31:0] d;
        logic        cl, ce;
        logic [7:0]  hi;
        {op, a, d, cl, ce} = v;
        hi = a[15:8] | {cl, 7'b0};
        for (int k = 0; k < 10; k++) exp_b[k] = 8'h00;
        exp_b[0] = op;
        case (op)
            8'hCA: begin exp_b[1]=a[23:16]; exp_b[2]=a[15:8]; exp_b[3]=a[7:0]; exp_n=4; end
            8'hC4: begin exp_b[1]=hi; exp_b[2]=a[7:0]; exp_b[3]=8'h00; exp_n=4; end
            8'hCF: begin exp_n=4; end
            8'hC1, 8'hC2: begin exp_b[1]=a[23:16]; exp_b[2]=a[15:8]; exp_b[3]=a[7:0];
                                exp_b[4]=d[15:8]; exp_b[5]=d[7:0]; exp_n=6; end
            8'hC7, 8'hC8: begin exp_b[1]=a[23:16]; exp_b[2]=a[15:8]; exp_b[3]=a[7:0];
                                exp_b[4]=d[23:16]; exp_b[5]=d[15:8]; exp_b[6]=d[7:0]; exp_n=7; end
            8'hC3: begin exp_b[1]=hi; exp_b[2]=a[7:0]; exp_b[3]=d[31:24]; exp_b[4]=d[23:16];
                         exp_b[5]=d[15:8]; exp_b[6]=d[7:0]; exp_n=7; end
            default: begin exp_b[1]=a[23:16]; exp_b[2]=a[15:8]; exp_b[3]=a[7:0];
                           exp_b[4]=d[31:24]; exp_b[5]=d[23:16]; exp_b[6]=d[15:8];
                           exp_b[7]=d[7:0]; exp_n=8; end
        endcase
        if (ce) begin
            exp_b[exp_n] = {crc_model(exp_n), 1'b1};
            exp_n++;
        end
    endtask

    // poke_at: byte index at whose handoff a second start is raised, -1 for none
    task automatic run_frame(input logic [65:0] v, input bit stall, input int poke_at);
        string rq;
        int    got = 0;
        int    cyc = 0;
        bit    prev_stall = 0;
        logic [7:0] prev_byte = '0;
        build_expect(v);
        rq = req_of(v[65:58], v[0], v[1]);
        @(negedge clk);
        {op_i, addr_i, arg_i, clockless_i, crc_en_i} = v;
        start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        chk(len_o == 4'(exp_n), "R2", len_o, exp_n);
        while (busy_o && cyc < 64) begin
            out_ready_i = stall ? ((cyc % 3) != 1) : 1'b1;
            if (prev_stall)
                chk(out_valid_o && out_byte_o == prev_byte, "R9", out_byte_o, prev_byte);
            if (out_valid_o && out_ready_i) begin
                chk(got < exp_n && out_byte_o == exp_b[got], rq, out_byte_o, exp_b[got]);
                if (got == poke_at) begin
                    start_i = 1'b1;
                    op_i = 8'hCA;
                end
                got++;
                prev_stall = 0;
            end else begin
                prev_stall = out_valid_o;
                prev_byte  = out_byte_o;
            end
            @(posedge clk);
            @(negedge clk);
            start_i = 1'b0;
            cyc++;
        end
        out_ready_i = 1'b1;
        chk(got == exp_n, rq, got, exp_n);
        if (poke_at >= 0)
            chk(!busy_o && !out_valid_o, "R11", {busy_o, out_valid_o}, 0);
    endtask

    task automatic run_illegal(input logic [7:0] op);
        @(negedge clk);
        op_i = op; crc_en_i = 1'b1; start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        chk(err_o == 1'b1, "R10", err_o, 1);
        chk(!out_valid_o && !busy_o && len_o == 0, "R10", {out_valid_o, busy_o, len_o}, 0);
        @(negedge clk);
        chk(err_o == 1'b0 && !out_valid_o, "R10", {err_o, out_valid_o}, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy_o && !out_valid_o && !err_o && len_o == 0, "R1",
            {busy_o, out_valid_o, err_o, len_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !out_valid_o && !err_o && len_o == 0, "R1",
            {busy_o, out_valid_o, err_o, len_o}, 0);

        for (int i = 0; i < NV; i++) run_frame(VEC[i], 1'b0, -1);
        for (int i = 0; i < NV; i++) run_frame(VEC[i], 1'b1, -1);

        // R11: second start at the final handoff, and in the middle of a body
        run_frame(VEC[7], 1'b0, 8);
        run_frame(VEC[6], 1'b1, 7);
        run_frame(VEC[4], 1'b1, 2);

        // R10: unsupported opcodes
        run_illegal(8'hC5);
        run_illegal(8'hC6);
        run_illegal(8'h00);
        run_frame(VEC[1], 1'b0, -1);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule